// File: doc/BRIEF.md
# Pin-Change Interrupt Controller

This block turns up to four external pins into interrupt requests, each pin having its own request output. Every pin passes through a two-flop synchroniser before a per-pin detector decides whether a trigger condition has occurred. A pin can trigger on a falling edge, a rising edge, any transition, a high level or a low level. Detected events are latched into a status bit. Software acknowledges an event through a clear bit and gates each output with an enable bit.

All controls share one 32-bit register. It holds six fields of `FW` bits each, one bit per pin in each field. The bit for pin `i` in field `f` sits at position `i + f*FW`. The field indices are 0 sense, 1 status, 2 clear, 3 enable, 4 any-edge and 5 level. The register is written synchronously through a write strobe and data word. It is read at any time through a combinational read bus.

With the default `CLR_HOLD = 1`, a clear bit left at 1 keeps that pin's status at 0. Software must therefore write the bit back to 0 before new events can latch. In every mode, writing a 1 to a clear bit removes the pending status on the clock edge of that write.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset the register reads 0 and every request output is 0.
- R2: For pin `i`, the sense, clear, enable, any-edge and level bits are written and read back at position `i + f*FW`, with f = 0, 2, 3, 4, 5 respectively (default FW = 4).
- R3: Status bits (field 1) ignore writes, and bits at or above `6*FW` always read 0.
- R4: With level = 0, any-edge = 0 and sense = 0, a falling edge on a pin sets its status, a rising edge does not, and a latched edge status stays set until it is cleared.
- R5: With level = 0, any-edge = 0 and sense = 1, a rising edge sets the status and a falling edge does not.
- R6: With level = 0 and any-edge = 1, either transition sets the status, whatever the sense bit holds.
- R7: With level = 1, the status follows the pin: it is 1 while the pin is high (sense = 1) or low (sense = 0), and 0 otherwise.
- R8: A request output equals the pin's status ANDed with its enable bit. A status with enable 0 stays latched and shows at the output once the enable is set.
- R9: Writing 1 to a clear bit clears the status. While the clear bit stays 1, the status stays 0 and edges are dropped. After the bit returns to 0, new edges latch again.
- R10: A pin change made between clock edges appears in the status after the third rising clock edge and not after the second.
- R11: Each pin drives only its own request output; an event on one pin leaves the other outputs at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | REG_W | Register write data |
| cfg_rdata | output | REG_W | Register read data |
| pin_in | input | NUM_IN | External interrupt pins (asynchronous) |
| irq_out | output | NUM_IN | Per-pin interrupt requests |

## Verification
The bench tests each trigger mode against its opposite transition. A detector with the sense polarity inverted, or with a both-edge path that still looks at sense, would latch on the wrong edge or miss one. The bench holds a clear bit high while toggling the pin, which catches a clear implemented as a one-cycle pulse. It writes a zero into a set status bit, which catches a status that software can write. It also counts the exact edge on which a status appears, which exposes a missing or extra synchroniser stage. Finally, it sets a status with the output disabled and then enables it, which catches an enable that gates detection rather than the output.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

   localparam int F_SENSE  = 0;
   localparam int F_STAT   = 1;
   localparam int F_CLR    = 2;
   localparam int F_EN     = 3;
   localparam int F_ANY    = 4;
   localparam int F_LVL    = 5;
   localparam int N_FIELDS = 6;

   // per-pin trigger controls as seen by one detector
   typedef struct packed {
      logic sense;
      logic clr;
      logic any;
      logic lvl;
   } xirq_mode_t;

   function automatic int bitpos(input int idx, input int fld, input int fw);
      return idx + fld * fw;
   endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
   parameter int NUM_IN   = 4,
   parameter int SYNC_LEN = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IN-1:0] pin_in,
   output logic [NUM_IN-1:0] cur,
   output logic [NUM_IN-1:0] prev,
   output logic              ready
);
   localparam int PRIME = SYNC_LEN + 1;
   localparam int CW    = $clog2(PRIME + 1);

   logic [NUM_IN-1:0] chain [SYNC_LEN];
   logic [CW-1:0]     cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < SYNC_LEN; k++) chain[k] <= '0;
         prev  <= '0;
         cnt_q <= '0;
      end else begin
         chain[0] <= pin_in;
         for (int k = 1; k < SYNC_LEN; k++) chain[k] <= chain[k-1];
         prev <= chain[SYNC_LEN-1];
         if (cnt_q != PRIME[CW-1:0]) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cur   = chain[SYNC_LEN-1];
   // detection waits until both cur and prev hold real samples
   assign ready = (cnt_q == PRIME[CW-1:0]);

endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
   import xirq_pkg::*;
#(
   parameter bit CLR_HOLD = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ready,
   input  logic       cur,
   input  logic       prev,
   input  xirq_mode_t mode,
   input  logic       clr_wr,
   output logic       stat
);
   logic hit;
   logic clr_act;

   always_comb begin
      if (!ready)         hit = 1'b0;
      else if (mode.lvl)  hit = mode.sense ? cur : ~cur;
      else if (mode.any)  hit = cur ^ prev;
      else if (mode.sense) hit = cur & ~prev;
      else                hit = ~cur & prev;
   end

   generate
      if (CLR_HOLD) begin : g_hold
         assign clr_act = clr_wr | mode.clr;
      end else begin : g_pulse
         assign clr_act = clr_wr;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          stat <= 1'b0;
      else if (clr_act)    stat <= 1'b0;
      else if (mode.lvl)   stat <= hit;
      else if (hit)        stat <= 1'b1;
   end

endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
   import xirq_pkg::*;
#(
   parameter int NUM_IN   = 4,
   parameter int FW       = 4,
   parameter int REG_W    = 32,
   parameter int SYNC_LEN = 2,
   parameter bit CLR_HOLD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [REG_W-1:0]  cfg_rdata,
   input  logic [NUM_IN-1:0] pin_in,
   output logic [NUM_IN-1:0] irq_out
);

   function automatic logic [REG_W-1:0] calc_wr_mask();
      logic [REG_W-1:0] m = '0;
      for (int f = 0; f < N_FIELDS; f++)
         if (f != F_STAT)
            for (int i = 0; i < NUM_IN; i++) m[bitpos(i, f, FW)] = 1'b1;
      return m;
   endfunction

   localparam logic [REG_W-1:0] WR_MASK = calc_wr_mask();

   initial begin
      assert (NUM_IN >= 1 && NUM_IN <= 4) else $error("NUM_IN must be 1..4");
      assert (FW >= NUM_IN) else $error("FW must cover NUM_IN");
      assert (N_FIELDS * FW <= REG_W) else $error("fields exceed REG_W");
      assert (SYNC_LEN >= 2) else $error("SYNC_LEN must be at least 2");
   end

   logic [REG_W-1:0]  ctl_q;
   logic [REG_W-1:0]  stat_bits;
   logic [NUM_IN-1:0] cur, prev, stat;
   logic              ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (cfg_we) ctl_q <= cfg_wdata & WR_MASK;
   end

   xirq_sync #(.NUM_IN(NUM_IN), .SYNC_LEN(SYNC_LEN)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
      .cur(cur), .prev(prev), .ready(ready)
   );

   generate
      for (genvar i = 0; i < NUM_IN; i++) begin : g_pin
         xirq_mode_t mode;
         assign mode.sense = ctl_q[bitpos(i, F_SENSE, FW)];
         assign mode.clr   = ctl_q[bitpos(i, F_CLR, FW)];
         assign mode.any   = ctl_q[bitpos(i, F_ANY, FW)];
         assign mode.lvl   = ctl_q[bitpos(i, F_LVL, FW)];

         xirq_detect #(.CLR_HOLD(CLR_HOLD)) u_det (
            .clk(clk), .rst_n(rst_n), .ready(ready),
            .cur(cur[i]), .prev(prev[i]), .mode(mode),
            .clr_wr(cfg_we & cfg_wdata[bitpos(i, F_CLR, FW)]),
            .stat(stat[i])
         );

         assign irq_out[i] = stat[i] & ctl_q[bitpos(i, F_EN, FW)];
      end
   endgenerate

   always_comb begin
      stat_bits = '0;
      for (int i = 0; i < NUM_IN; i++) stat_bits[bitpos(i, F_STAT, FW)] = stat[i];
   end

   assign cfg_rdata = ctl_q | stat_bits;

endmodule

// File: rtl/xirq_ctrl_chk.sv
module xirq_ctrl_chk
   import xirq_pkg::*;
#(
   parameter int NUM_IN   = 4,
   parameter int FW       = 4,
   parameter int REG_W    = 32,
   parameter bit CLR_HOLD = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [REG_W-1:0]  cfg_wdata,
   input logic [REG_W-1:0]  cfg_rdata,
   input logic [NUM_IN-1:0] irq_out
);
   generate
      for (genvar i = 0; i < NUM_IN; i++) begin : g_chk
         localparam int PS = bitpos(i, F_STAT, FW);
         localparam int PC = bitpos(i, F_CLR, FW);
         localparam int PE = bitpos(i, F_EN, FW);
         localparam int PL = bitpos(i, F_LVL, FW);

         // R8: a disabled pin never requests
         a_r8_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_rdata[PE] |-> !irq_out[i]);

         // R2: enable bit reads back what was written
         a_r2_wr_readback: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_we |=> cfg_rdata[PE] == $past(cfg_wdata[PE]));

         // R4: latched edge status persists without a clear
         a_r4_edge_latch: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_rdata[PL] && cfg_rdata[PS] && !cfg_rdata[PC] &&
             !(cfg_we && cfg_wdata[PC])) |=> cfg_rdata[PS]);

         if (CLR_HOLD) begin : g_hold
            // R9: a held clear bit keeps status at 0
            a_r9_hold_clear: assert property (@(posedge clk) disable iff (!rst_n)
               cfg_rdata[PC] |=> !cfg_rdata[PS]);
         end
      end

      if (N_FIELDS * FW < REG_W) begin : g_top
         // R3: bits above the fields read 0
         a_r3_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_rdata[REG_W-1:N_FIELDS*FW] == '0);
      end
   endgenerate
endmodule

bind xirq_ctrl xirq_ctrl_chk #(
   .NUM_IN(NUM_IN), .FW(FW), .REG_W(REG_W), .CLR_HOLD(CLR_HOLD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
   .cfg_rdata(cfg_rdata), .irq_out(irq_out)
);

// File: tb/xirq_ctrl_tb.sv
`timescale 1ns/1ps
module xirq_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [3:0]  pins = '0;
   logic [3:0]  irq_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   xirq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .pin_in(pins), .irq_out(irq_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = d;
      @(posedge clk);
      #1;
      cfg_we = 1'b0;
   endtask

   task automatic set_pin(input int i, input logic v);
      @(negedge clk);
      pins[i] = v;
   endtask

   task automatic cleanup();
      wr(32'h0000_0F00);
      wr(32'h0);
      cyc(1);
   endtask

   task automatic t_reset();
      cyc(6);
      chk("R1 rdata", cfg_rdata, 32'h0);
      chk("R1 irq", {28'h0, irq_out}, 32'h0);
   endtask

   task automatic t_regmap();
      wr(32'hFFFF_FFFF);
      chk("R2/R3 all-ones readback", cfg_rdata, 32'h00FF_FF0F);
      wr(32'h0000_4000);
      chk("R2 enable pin2 at bit14", cfg_rdata, 32'h0000_4000);
      wr(32'h0020_0002);
      chk("R2 sense1 bit1 level1 bit21", cfg_rdata, 32'h0020_0002);
      wr(32'h0000_00F0);
      chk("R3 status write ignored", cfg_rdata, 32'h0);
      cleanup();
   endtask

   task automatic t_fall();
      wr(32'h0000_1000);
      set_pin(0, 1'b1);
      cyc(4);
      chk("R4 rising ignored", {31'h0, cfg_rdata[4]}, 32'h0);
      set_pin(0, 1'b0);
      cyc(2);
      chk("R10 not after 2nd edge", {31'h0, cfg_rdata[4]}, 32'h0);
      cyc(1);
      chk("R10 set after 3rd edge", {31'h0, cfg_rdata[4]}, 32'h1);
      chk("R11 only irq0", {28'h0, irq_out}, 32'h1);
      cyc(5);
      chk("R4 latched", {31'h0, cfg_rdata[4]}, 32'h1);
      wr(32'h0000_1100);
      cyc(1);
      chk("R9 cleared", {31'h0, cfg_rdata[4]}, 32'h0);
      set_pin(0, 1'b1);
      cyc(3);
      set_pin(0, 1'b0);
      cyc(4);
      chk("R9 held clear drops edge", {31'h0, cfg_rdata[4]}, 32'h0);
      wr(32'h0000_1000);
      set_pin(0, 1'b1);
      cyc(3);
      set_pin(0, 1'b0);
      cyc(4);
      chk("R9 relatch after release", {31'h0, cfg_rdata[4]}, 32'h1);
      cleanup();
   endtask

   task automatic t_rise();
      wr(32'h0000_2002);
      set_pin(1, 1'b1);
      cyc(4);
      chk("R5 rising sets", {31'h0, cfg_rdata[5]}, 32'h1);
      chk("R11 only irq1", {28'h0, irq_out}, 32'h2);
      wr(32'h0000_2202);
      wr(32'h0000_2002);
      set_pin(1, 1'b0);
      cyc(4);
      chk("R5 falling ignored", {31'h0, cfg_rdata[5]}, 32'h0);
      cleanup();
   endtask

   task automatic t_any();
      wr(32'h0008_8000);
      set_pin(3, 1'b1);
      cyc(4);
      chk("R6 rise sense0", {31'h0, cfg_rdata[7]}, 32'h1);
      wr(32'h0008_8808);
      wr(32'h0008_8008);
      set_pin(3, 1'b0);
      cyc(4);
      chk("R6 fall sense1", {31'h0, cfg_rdata[7]}, 32'h1);
      chk("R11 only irq3", {28'h0, irq_out}, 32'h8);
      cleanup();
   endtask

   task automatic t_level();
      wr(32'h0040_4004);
      set_pin(2, 1'b1);
      cyc(4);
      chk("R7 high level", {31'h0, cfg_rdata[6]}, 32'h1);
      chk("R7 irq2", {28'h0, irq_out}, 32'h4);
      set_pin(2, 1'b0);
      cyc(4);
      chk("R7 follows pin low", {31'h0, cfg_rdata[6]}, 32'h0);
      wr(32'h0040_4000);
      cyc(1);
      chk("R7 low level", {31'h0, cfg_rdata[6]}, 32'h1);
      cleanup();
   endtask

   task automatic t_enable();
      set_pin(0, 1'b1);
      cyc(4);
      set_pin(0, 1'b0);
      cyc(4);
      chk("R8 status latched while disabled", {31'h0, cfg_rdata[4]}, 32'h1);
      chk("R8 irq suppressed", {28'h0, irq_out}, 32'h0);
      wr(32'h0000_1000);
      chk("R3 zero write keeps status", {31'h0, cfg_rdata[4]}, 32'h1);
      chk("R8 irq after enable", {28'h0, irq_out}, 32'h1);
      cleanup();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_regmap();
      t_fall();
      t_rise();
      t_any();
      t_level();
      t_enable();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule